// File: doc/BRIEF.md
# Masked-Clear Event Pending Register

This block collects eight hardware event strobes from a three-phase PWM motor-control timer into an 8-bit register of pending flags and raises one combined interrupt request while any flag is set. The events are: a general compare match, a tacho capture, a tacho counter overflow, a preload-to-compare transfer, the PWM counter reaching zero, and the compare matches of the U, V and W phases. Each event has its own enable bit. A disabled event is dropped. An enabled event sets its flag on the clock edge that samples the strobe.

Software reads the flags over a simple register bus and clears them by writing a mask. A zero in the mask clears that flag, and a one leaves it alone. Software can never set a flag. So clearing one flag cannot wipe out a different flag that hardware set in the meantime. The three phase-compare events are qualified by the counter mode. In edge-aligned mode every match counts. In zero-centered mode a match counts only while the counter runs in the direction picked by a direction-select input.

The request output is held in a small two-state machine. IRQ_IDLE moves to IRQ_ACTIVE when the next flag value is non-zero. IRQ_ACTIVE moves back to IRQ_IDLE when the next flag value becomes all zeros. Otherwise each state stays where it is.

Top module: `irq_pend_reg`

## Requirements
- R1: After reset (rst_n low) the flags read 8'h00 and irq is 0.
- R2: Flag bit positions, from MSB to LSB, are: bit 7 general compare, bit 6 tacho capture, bit 5 tacho overflow, bit 4 preload transfer, bit 3 counter zero, bit 2 phase U compare, bit 1 phase V compare, bit 0 phase W compare. evt[i] and en[i] use the same positions.
- R3: An event strobe evt[i] sampled with en[i]=1 sets flag i at that clock edge. With en[i]=0 the strobe leaves flag i unchanged.
- R4: A write with wr_data bit i = 1 leaves flag i unchanged. Software can never set a flag.
- R5: A write with wr_data bit i = 0 clears flag i at that edge. For example, writing 8'hFE clears only bit 0.
- R6: With centered=0 (edge-aligned mode), enabled phase-compare strobes (bits 2..0) set their flags whatever the values of count_down and dir_sel.
- R7: With centered=1, phase-compare strobes set flags only when count_down equals dir_sel (dir_sel 0 selects up-counting matches, dir_sel 1 selects down-counting matches). Bits 7..3 are never affected by mode or direction.
- R8: If a set event and a clearing write hit the same bit in the same cycle, the flag ends up at 1.
- R9: irq is a registered output equal to the OR of all flags. It stays 1 until every flag is cleared.
- R10: rd_data always shows the current flags. Reading has no side effects, so the flags hold steady over cycles with no event and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt | input | 8 | Single-cycle event strobes, bit order as in R2 |
| en | input | 8 | Per-event enable bits |
| centered | input | 1 | 1 = zero-centered counter mode, 0 = edge-aligned mode |
| count_down | input | 1 | Current counter direction, 1 = counting down |
| dir_sel | input | 1 | Direction whose phase matches count in centered mode, 1 = down |
| wr_en | input | 1 | Write strobe for the clear mask |
| wr_data | input | 8 | Clear mask: 0 clears, 1 keeps |
| rd_data | output | 8 | Current pending flags |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench targets the cycle where hardware sets a flag and software clears the same flag. A design that let the clear win would silently lose that event. It writes all-ones masks to catch a design that treats the write as a plain store and sets flags from software, and it writes single-zero masks to catch one that clears more than the chosen bit. It runs centered mode with every combination of direction and direction-select, looking for phase flags set in the wrong direction and for non-phase flags that the mode wrongly gates. It also clears the last remaining flag and checks that irq drops in the same cycle and not one cycle late.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
    localparam int NUM_EVT   = 8;
    localparam int NUM_PHASE = 3;

    localparam int BIT_CMP0  = 7;
    localparam int BIT_CAPT  = 6;
    localparam int BIT_OVF   = 5;
    localparam int BIT_XFER  = 4;
    localparam int BIT_ZERO  = 3;
    localparam int BIT_PH_U  = 2;
    localparam int BIT_PH_V  = 1;
    localparam int BIT_PH_W  = 0;

    typedef enum logic [0:0] {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_e;
endpackage

// File: rtl/irq_pend_qual.sv
module irq_pend_qual #(
    parameter int N_EVT   = irq_pend_pkg::NUM_EVT,
    parameter int N_PHASE = irq_pend_pkg::NUM_PHASE
) (
    input  logic [N_EVT-1:0] evt,
    input  logic [N_EVT-1:0] en,
    input  logic             centered,
    input  logic             count_down,
    input  logic             dir_sel,
    output logic [N_EVT-1:0] set_req
);
    logic dir_ok;

    // Phase matches pass in edge-aligned mode, or in centered mode when
    // the counter runs in the selected direction.
    assign dir_ok = !centered || (count_down == dir_sel);

    for (genvar i = 0; i < N_EVT; i++) begin : g_qual
        if (i < N_PHASE) begin : g_phase
            assign set_req[i] = evt[i] && en[i] && dir_ok;
        end else begin : g_plain
            assign set_req[i] = evt[i] && en[i];
        end
    end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int N_EVT = irq_pend_pkg::NUM_EVT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] set_req,
    input  logic             wr_en,
    input  logic [N_EVT-1:0] wr_data,
    output logic [N_EVT-1:0] flags,
    output logic [N_EVT-1:0] flags_nxt
);
    logic [N_EVT-1:0] keep_mask;

    assign keep_mask = wr_en ? wr_data : {N_EVT{1'b1}};

    for (genvar i = 0; i < N_EVT; i++) begin : g_bit
        // A hardware set overrides a software clear in the same cycle.
        assign flags_nxt[i] = set_req[i] || (flags[i] && keep_mask[i]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= flags_nxt[i];
        end
    end

    // A flag may rise only where hardware requested a set.
    p_no_sw_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ~$past(flags) & ~$past(set_req)) == '0));

    // A zero in the written mask clears the bit unless a set coincided.
    p_mask_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> ((flags & ~$past(wr_data) & ~$past(set_req)) == '0));

    // Every requested set is visible after the edge.
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(set_req) & ~flags) == '0));

    // Without a write and without events, flags hold.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && ($past(set_req) == '0)) |-> (flags == $past(flags)));
endmodule

// File: rtl/irq_pend_req.sv
module irq_pend_req #(
    parameter int N_EVT = irq_pend_pkg::NUM_EVT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] flags_nxt,
    input  logic [N_EVT-1:0] flags,
    output logic             irq
);
    import irq_pend_pkg::*;

    irq_state_e state, state_nxt;
    logic       any_nxt;

    assign any_nxt = |flags_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            IRQ_IDLE:   if (any_nxt)  state_nxt = IRQ_ACTIVE;
            IRQ_ACTIVE: if (!any_nxt) state_nxt = IRQ_IDLE;
            default:    state_nxt = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IRQ_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        irq = (state == IRQ_ACTIVE);
    end

    // Request tracks the registered flag vector cycle for cycle.
    p_irq_or_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|flags));
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
    parameter int N_EVT   = irq_pend_pkg::NUM_EVT,
    parameter int N_PHASE = irq_pend_pkg::NUM_PHASE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt,
    input  logic [N_EVT-1:0] en,
    input  logic             centered,
    input  logic             count_down,
    input  logic             dir_sel,
    input  logic             wr_en,
    input  logic [N_EVT-1:0] wr_data,
    output logic [N_EVT-1:0] rd_data,
    output logic             irq
);
    logic [N_EVT-1:0] set_req;
    logic [N_EVT-1:0] flags;
    logic [N_EVT-1:0] flags_nxt;

    irq_pend_qual #(.N_EVT(N_EVT), .N_PHASE(N_PHASE)) u_qual (
        .evt        (evt),
        .en         (en),
        .centered   (centered),
        .count_down (count_down),
        .dir_sel    (dir_sel),
        .set_req    (set_req)
    );

    irq_pend_bank #(.N_EVT(N_EVT)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_req   (set_req),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .flags     (flags),
        .flags_nxt (flags_nxt)
    );

    irq_pend_req #(.N_EVT(N_EVT)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .flags_nxt (flags_nxt),
        .flags     (flags),
        .irq       (irq)
    );

    assign rd_data = flags;

    // Disabled strobes never leave a mark on their flag.
    p_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_data & ~$past(rd_data) & ~$past(en)) == '0));

    // Centered mode in the wrong direction never raises a phase flag.
    p_dir_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(centered) && ($past(count_down) != $past(dir_sel)))
        |-> ((rd_data[N_PHASE-1:0] & ~$past(rd_data[N_PHASE-1:0])) == '0));
endmodule

// File: tb/irq_pend_reg_bench.sv
module irq_pend_reg_bench;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt = '0;
    logic [7:0] en = '0;
    logic       centered = 1'b0;
    logic       count_down = 1'b0;
    logic       dir_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_flags = '0;

    always #(PERIOD/2) clk = ~clk;

    irq_pend_reg u_irq_pend_reg (
        .clk(clk), .rst_n(rst_n), .evt(evt), .en(en), .centered(centered),
        .count_down(count_down), .dir_sel(dir_sel), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [7:0] model_next(
        input logic [7:0] cur, input logic [7:0] e, input logic [7:0] m,
        input logic cm, input logic dn, input logic ds,
        input logic w, input logic [7:0] wd);
        logic [7:0] q;
        q = e & m;
        if (cm && (dn != ds)) q[2:0] = 3'b000;
        return (cur & (w ? wd : 8'hFF)) | q;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, expv);
        end
    endtask

    task automatic step(input logic [7:0] e, input logic [7:0] m, input logic cm,
                        input logic dn, input logic ds, input logic w,
                        input logic [7:0] wd, input string req);
        @(negedge clk);
        evt = e; en = m; centered = cm; count_down = dn; dir_sel = ds;
        wr_en = w; wr_data = wd;
        exp_flags = model_next(exp_flags, e, m, cm, dn, ds, w, wd);
        @(posedge clk);
        #(PERIOD/4);
        evt = '0; wr_en = 1'b0;
        chk(req, rd_data, exp_flags);
        chk({req, " R9 irq"}, {7'd0, irq}, {7'd0, |exp_flags});
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 flags", rd_data, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        step(8'h00, 8'hFF, 0, 0, 0, 1, 8'hFF, "R4 write ones");
        step(8'h80, 8'hFF, 0, 0, 0, 0, 8'h00, "R2 bit7 compare0");
        step(8'hFF, 8'h00, 0, 0, 0, 0, 8'h00, "R3 disabled");
        step(8'h40, 8'hBF, 0, 0, 0, 0, 8'h00, "R3 one disabled");
        step(8'h7F, 8'hFF, 0, 1, 0, 0, 8'h00, "R6 classical");
        step(8'h00, 8'hFF, 0, 0, 0, 1, 8'hFE, "R5 clear W only");
        step(8'h01, 8'hFF, 0, 0, 0, 1, 8'h00, "R8 set beats clear");
        step(8'h00, 8'hFF, 0, 0, 0, 1, 8'h00, "R9 last clear");
        step(8'h07, 8'hFF, 1, 1, 0, 0, 8'h00, "R7 down vs up-select");
        step(8'h07, 8'hFF, 1, 0, 0, 0, 8'h00, "R7 up with up-select");
        step(8'h00, 8'hFF, 1, 0, 0, 1, 8'h00, "R5 clear all");
        step(8'h07, 8'hFF, 1, 0, 1, 0, 8'h00, "R7 up vs down-select");
        step(8'h0F, 8'hFF, 1, 1, 0, 0, 8'h00, "R7 non-phase ungated");
        step(8'h07, 8'hFF, 1, 1, 1, 0, 8'h00, "R7 down with down-select");
        for (int k = 0; k < 4; k++) step(8'h00, 8'hFF, 0, 0, 0, 0, 8'h00, "R10 hold");
        for (int k = 0; k < 600; k++) begin
            logic [7:0] re, rm, rw;
            re = 8'($urandom);
            rm = 8'($urandom) | 8'($urandom);
            rw = 8'($urandom) | 8'($urandom);
            step(($urandom % 3 == 0) ? re : 8'h00, rm, 1'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), rw, "R3 R5 R7 R10 random");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule